// File: doc/BRIEF.md
# Warp Issue Steering Stage

This block is the issue stage of a single GPU sub-core. Each clock it looks at the head of an in-order instruction queue and takes at most one decoded warp instruction. It sorts the instruction by class and sends it to one of three arithmetic pipes, or to a side port for every other kind of instruction. The three pipes are a heavy multiply-add pipe, a light floating-point pipe and an integer/compare pipe.

Each pipe has 16 lanes and a warp has 32 threads. An arithmetic instruction therefore runs as two half-warp passes on consecutive cycles, and its pipe stays occupied for both. The block tracks which pipes are occupied and holds the queue head when its class has no free pipe. It keeps issue and busy-cycle counters for each pipe so that rate limits can be observed from outside.

Top module: `warp_issue_steer`

## Requirements
- R1: At most one instruction issues per clock (`iss_valid` is one signal). In any cycle at most one pipe shows a pass with `pass_half` = 0.
- R2: Class codes on `in_class` are 0 = float add/mul/fused multiply-add, 1 = integer multiply-add, 2 = integer add/logic, 3 = float compare/min/max, 4..7 = other. Pipe codes on `iss_pipe` are 0 = heavy, 1 = light, 2 = integer, 3 = other port. Class 0 goes to the light pipe when it is free, and otherwise to the heavy pipe.
- R3: Class 1 issues only to the heavy pipe. It stalls while the heavy pipe is in the first pass of an earlier instruction.
- R4: Classes 2 and 3 issue only to the integer pipe. They stall while that pipe is in its first pass.
- R5: Classes 4..7 are always ready. They issue with `iss_pipe` = 3 and produce no pipe pass.
- R6: One cycle after a pipe accepts an instruction, the pipe shows pass 0: its `pass_valid` bit is 1, its `pass_half` bit is 0 and its lane mask is 0x0000FFFF. In the cycle after that it shows pass 1: `pass_half` bit 1 and lane mask 0xFFFF0000. The pipe index p selects bit p of `pass_valid`/`pass_half` and bits [32p+31:32p] of `pass_lanes`.
- R7: A pipe never accepts instructions on two consecutive clocks. It may accept again in the cycle in which it shows pass 1.
- R8: While `in_ready` is 0, or `in_valid` is 0, nothing issues and no new pass starts.
- R9: For pipe p, `issue_cnt[16p+15:16p]` counts the instructions the pipe has accepted. `busy_cnt[16p+15:16p]` counts the cycles in which the pipe shows a pass.
- R10: While `rst_n` is low, all pass outputs and counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Queue head holds an instruction |
| in_class | input | 3 | Class code of the head instruction |
| in_ready | output | 1 | Head class has a free target this cycle |
| iss_valid | output | 1 | Head instruction issues this cycle |
| iss_pipe | output | 2 | Target of the issuing instruction |
| pass_valid | output | 3 | Per pipe: a pass is active |
| pass_half | output | 3 | Per pipe: half-warp index of the active pass |
| pass_lanes | output | 96 | Per pipe: 32-bit lane mask of the active pass |
| issue_cnt | output | 48 | Per pipe 16-bit accepted-instruction count |
| busy_cnt | output | 48 | Per pipe 16-bit occupied-cycle count |

## Verification
If a pipe's occupancy state is wrong, `in_ready` or `iss_pipe` for the next instruction of that class is wrong in the same cycle. The same fault makes a pass or lane mask appear out of order one cycle after the issue. A lost or doubled pass changes `busy_cnt` at once. A wrong steering choice shows up in `issue_cnt` as soon as the run's totals are read.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int NPIPE = 3;

  typedef enum logic [1:0] {
    PIPE_HEAVY = 2'd0,
    PIPE_LIGHT = 2'd1,
    PIPE_INT   = 2'd2,
    PIPE_OTHER = 2'd3
  } pipe_e;

  typedef enum logic [2:0] {
    CLS_FMAD = 3'd0,
    CLS_IMAD = 3'd1,
    CLS_IALU = 3'd2,
    CLS_FCMP = 3'd3,
    CLS_MISC = 3'd4
  } cls_e;
endpackage

// File: rtl/wis_steer.sv
module wis_steer
  import wis_pkg::*;
(
  input  logic [2:0]       cls,
  input  logic [NPIPE-1:0] first_busy,
  output logic             ok,
  output pipe_e            sel
);
  always_comb begin
    ok  = 1'b1;
    sel = PIPE_OTHER;
    case (cls)
      CLS_FMAD: begin
        if (!first_busy[PIPE_LIGHT]) sel = PIPE_LIGHT;
        else if (!first_busy[PIPE_HEAVY]) sel = PIPE_HEAVY;
        else ok = 1'b0;
      end
      CLS_IMAD: begin
        sel = PIPE_HEAVY;
        ok  = !first_busy[PIPE_HEAVY];
      end
      CLS_IALU, CLS_FCMP: begin
        sel = PIPE_INT;
        ok  = !first_busy[PIPE_INT];
      end
      default: begin
        sel = PIPE_OTHER;
        ok  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/wis_pipe_slot.sv
module wis_pipe_slot #(
  parameter int LANES = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  output logic               first,
  output logic               second,
  output logic [2*LANES-1:0] lanes,
  output logic [CNT_W-1:0]   icnt,
  output logic [CNT_W-1:0]   bcnt
);
  localparam logic [2*LANES-1:0] LO_MASK = {{LANES{1'b0}}, {LANES{1'b1}}};
  localparam logic [2*LANES-1:0] HI_MASK = {{LANES{1'b1}}, {LANES{1'b0}}};

  logic             first_d, second_d;
  logic             icnt_en, bcnt_en;
  logic [CNT_W-1:0] icnt_d, bcnt_d;

  always_comb begin
    first_d  = accept;
    second_d = first;
    icnt_en  = accept;
    bcnt_en  = first | second;
    icnt_d   = icnt + 1'b1;
    bcnt_d   = bcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first  <= 1'b0;
      second <= 1'b0;
    end else begin
      first  <= first_d;
      second <= second_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) icnt <= '0;
    else if (icnt_en) icnt <= icnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (bcnt_en) bcnt <= bcnt_d;
  end

  always_comb begin
    lanes = '0;
    if (first) lanes = LO_MASK;
    else if (second) lanes = HI_MASK;
  end

  assert_first_then_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    first |=> second);
  assert_accept_low_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (lanes == LO_MASK));
  assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    first |=> !first);
endmodule

// File: rtl/warp_issue_steer.sv
module warp_issue_steer
  import wis_pkg::*;
#(
  parameter int LANES = 16,
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [2:0]               in_class,
  output logic                     in_ready,
  output logic                     iss_valid,
  output logic [1:0]               iss_pipe,
  output logic [NPIPE-1:0]         pass_valid,
  output logic [NPIPE-1:0]         pass_half,
  output logic [NPIPE*2*LANES-1:0] pass_lanes,
  output logic [NPIPE*CNT_W-1:0]   issue_cnt,
  output logic [NPIPE*CNT_W-1:0]   busy_cnt
);
  logic [NPIPE-1:0] first_v, second_v, accept_v;
  logic             steer_ok;
  pipe_e            steer_sel;

  wis_steer u_steer (
    .cls        (in_class),
    .first_busy (first_v),
    .ok         (steer_ok),
    .sel        (steer_sel)
  );

  always_comb begin
    in_ready  = steer_ok;
    iss_valid = in_valid & steer_ok;
    iss_pipe  = steer_sel;
  end

  for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
    assign accept_v[g] = iss_valid && (steer_sel == pipe_e'(g));

    wis_pipe_slot #(.LANES(LANES), .CNT_W(CNT_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept_v[g]),
      .first  (first_v[g]),
      .second (second_v[g]),
      .lanes  (pass_lanes[g*2*LANES +: 2*LANES]),
      .icnt   (issue_cnt[g*CNT_W +: CNT_W]),
      .bcnt   (busy_cnt[g*CNT_W +: CNT_W])
    );

    assign pass_valid[g] = first_v[g] | second_v[g];
    assign pass_half[g]  = second_v[g];
  end

  assert_single_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pass_valid & ~pass_half) <= 1);
  assert_imad_heavy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && in_class == CLS_IMAD) |-> (iss_pipe == PIPE_HEAVY));
  assert_int_pipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (in_class == CLS_IALU || in_class == CLS_FCMP)) |-> (iss_pipe == PIPE_INT));
  assert_misc_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_class >= CLS_MISC) |-> in_ready);
  assert_idle_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ((pass_valid & ~pass_half) == '0));
endmodule

// File: tb/test_warp_issue_steer.sv
module test_warp_issue_steer;
  logic        clk, rst_n, in_valid;
  logic [2:0]  in_class;
  logic        in_ready, iss_valid;
  logic [1:0]  iss_pipe;
  logic [2:0]  pass_valid, pass_half;
  logic [95:0] pass_lanes;
  logic [47:0] issue_cnt, busy_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  warp_issue_steer i_warp_issue_steer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_ready(in_ready), .iss_valid(iss_valid), .iss_pipe(iss_pipe),
    .pass_valid(pass_valid), .pass_half(pass_half), .pass_lanes(pass_lanes),
    .issue_cnt(issue_cnt), .busy_cnt(busy_cnt)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // {valid, class[2:0], ready, pipe[1:0], pass_valid[2:0], pass_half[2:0]}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 3'd0, 1'b1, 2'd1, 3'b010, 3'b000}, // R2 light first
    {1'b1, 3'd0, 1'b1, 2'd0, 3'b011, 3'b010}, // R2 fallback heavy
    {1'b1, 3'd0, 1'b1, 2'd1, 3'b011, 3'b001}, // R7 light again at pass 1
    {1'b1, 3'd1, 1'b1, 2'd0, 3'b011, 3'b010}, // R3 heavy
    {1'b1, 3'd1, 1'b0, 2'd0, 3'b001, 3'b001}, // R3 stall
    {1'b1, 3'd1, 1'b1, 2'd0, 3'b001, 3'b000}, // R3 retry
    {1'b1, 3'd2, 1'b1, 2'd2, 3'b101, 3'b001}, // R4 int add
    {1'b1, 3'd3, 1'b0, 2'd2, 3'b100, 3'b100}, // R4 stall
    {1'b1, 3'd4, 1'b1, 2'd3, 3'b000, 3'b000}, // R5 other
    {1'b1, 3'd3, 1'b1, 2'd2, 3'b100, 3'b000}, // R4 compare
    {1'b0, 3'd0, 1'b1, 2'd1, 3'b100, 3'b100}, // R8 idle
    {1'b1, 3'd0, 1'b1, 2'd1, 3'b010, 3'b000}, // R2
    {1'b1, 3'd7, 1'b1, 2'd3, 3'b010, 3'b010}, // R5 code 7
    {1'b1, 3'd0, 1'b1, 2'd1, 3'b010, 3'b000}  // R7
  };

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] lanes_of(input logic [2:0] pv, input logic [2:0] ph);
    logic [95:0] m = '0;
    for (int p = 0; p < 3; p++)
      if (pv[p]) m[p*32 +: 32] = ph[p] ? 32'hFFFF0000 : 32'h0000FFFF;
    return m;
  endfunction

  task automatic chk_pass(input logic [2:0] pv, input logic [2:0] ph, input string req);
    chk(pass_valid == pv, req, 96'(pass_valid), 96'(pv));
    chk(pass_half == ph, req, 96'(pass_half), 96'(ph));
    chk(pass_lanes == lanes_of(pv, ph), "R6 lanes", pass_lanes, lanes_of(pv, ph));
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] prev;
    rst_n = 0; in_valid = 0; in_class = 3'd0;
    prev = '0;
    #1;
    chk(pass_valid == 3'b000, "R10 pass", 96'(pass_valid), 96'd0);
    chk(issue_cnt == '0 && busy_cnt == '0, "R10 cnt", 96'(issue_cnt), 96'd0);
    repeat (2) @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) chk_pass(prev[5:3], prev[2:0], "R6/R7 pass");
      in_valid = VEC[i][12];
      in_class = VEC[i][11:9];
      #1;
      chk(in_ready == VEC[i][8], "R3/R4 ready", 96'(in_ready), 96'(VEC[i][8]));
      chk(iss_valid == (VEC[i][12] & VEC[i][8]), "R1/R8 issue", 96'(iss_valid), 96'(VEC[i][12] & VEC[i][8]));
      if (VEC[i][12] && VEC[i][8])
        chk(iss_pipe == VEC[i][7:6], "R2 pipe", 96'(iss_pipe), 96'(VEC[i][7:6]));
      prev = VEC[i];
    end
    @(negedge clk);
    chk_pass(prev[5:3], prev[2:0], "R6 last pass");
    in_valid = 0;
    @(negedge clk);
    chk_pass(3'b010, 3'b010, "R6 final half");
    @(negedge clk);
    chk_pass(3'b000, 3'b000, "R8 drained");
    chk(issue_cnt[15:0] == 16'd3, "R9 heavy issues", 96'(issue_cnt[15:0]), 96'd3);
    chk(issue_cnt[31:16] == 16'd4, "R9 light issues", 96'(issue_cnt[31:16]), 96'd4);
    chk(issue_cnt[47:32] == 16'd2, "R9 int issues", 96'(issue_cnt[47:32]), 96'd2);
    chk(busy_cnt[15:0] == 16'd6, "R9 heavy busy", 96'(busy_cnt[15:0]), 96'd6);
    chk(busy_cnt[31:16] == 16'd8, "R9 light busy", 96'(busy_cnt[31:16]), 96'd8);
    chk(busy_cnt[47:32] == 16'd4, "R9 int busy", 96'(busy_cnt[47:32]), 96'd4);

    // R10: reset in the middle of a pass
    in_valid = 1; in_class = 3'd2;
    @(negedge clk);
    in_valid = 0;
    chk_pass(3'b100, 3'b000, "R4 int pass0");
    rst_n = 0;
    #1;
    chk_pass(3'b000, 3'b000, "R10 mid reset");
    chk(busy_cnt == '0 && issue_cnt == '0, "R10 cnt clear", 96'(busy_cnt), 96'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_pass(3'b000, 3'b000, "R10 after reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule